// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Violation Detection

This block holds the in-flight loads of one execution thread in a circular queue and watches for loads that read memory before an older store to the same region has executed. Each load takes the queue slot at the tail when it is allocated. It learns its address later, through a separate writeback port. The block also keeps a small store tracker with a tail index and an occupancy count. Each new load is tagged with the store tail at the time it is allocated. Each new store is handed the current load tail, so that it knows where the loads younger than itself begin.

When a store executes, the block presents that recorded load index together with the store address. In the same cycle it searches the ring from that index up to the load tail, comparing addresses at a granule of `2**GRAN_SHIFT` bytes. The oldest matching load is captured as the violator, and a one-cycle fault pulse goes out. The captured violator stays until the consumer reads it, and while it is held no further search is made. Loads retire in order from the head up to a youngest sequence number. A squash removes loads from the tail backward and also clears the stall and blocked-load tracking state where the squash makes it stale. A free-entry output gives the room left in the tighter of the two queues.

Top module: `ldq_order_guard`

## Requirements
- R1: After reset both queues are empty: `o_lq_count` is 0, `o_free` is min(LQ_DEPTH, SQ_DEPTH), and `o_viol_vld`, `o_st_fault`, `o_ld_full`, `o_stalled` and `o_blocked` are all 0.
- R2: While `i_ld_alloc` is high, `o_ld_alloc_idx` shows the load tail slot that the load receives, and successive allocations take slots 0..LQ_DEPTH in ring order. `o_ld_alloc_sq_none` is 1 when no store is tracked; otherwise it is 0 and `o_ld_alloc_sqidx` gives the store tail. When `o_lq_count` equals LQ_DEPTH, `o_ld_full` is 1 and an allocation request is dropped.
- R3: While `i_st_alloc` is high, `o_st_alloc_ldidx` gives the current load tail. A store allocation advances the store tail (ring of SQ_DEPTH+1 slots) unless SQ_DEPTH stores are already tracked, in which case `o_st_full` is 1 and the request is dropped. `i_st_retire` releases one tracked store.
- R4: `o_free` equals min(LQ_DEPTH+1-loads, SQ_DEPTH+1-stores) - 1.
- R5: On `i_st_exec` with no violator held, the slots from `i_st_ldidx` up to but excluding the load tail are searched in ring order. The first live load whose `addr >> GRAN_SHIFT` equals the store's `addr >> GRAN_SHIFT` raises `o_st_fault` in that cycle, and from the next cycle its slot and sequence number appear on `o_viol_idx` and `o_viol_seq` with `o_viol_vld` high. Loads outside the searched range never match.
- R6: A load whose address has not yet been written never matches a store.
- R7: While a violator is held, store executions raise no fault and leave the held values unchanged. `i_viol_read` clears `o_viol_vld` on the next cycle.
- R8: `i_commit` removes head entries in one cycle, for as long as the queue is nonempty and the head sequence number is not greater than `i_commit_seq`.
- R9: `i_squash` removes entries from the newest backward, for as long as their sequence number is greater than `i_squash_seq`. The tail moves back, so the next allocation reuses the first freed slot.
- R10: `i_stall_set` records a stalled load slot (`o_stalled` high). A squash that removes that slot clears `o_stalled`; a squash that leaves it in place keeps `o_stalled` high.
- R11: `i_block_set` records a blocked load sequence number (`o_blocked` high). A squash clears `o_blocked` only when `i_squash_seq` is smaller than that recorded number.
- R12: In a cycle with `i_squash` high, load allocation and commit requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_ld_alloc | input | 1 | Allocate a load at the tail |
| i_ld_seq | input | SEQ_W | Sequence number of the allocated load |
| o_ld_alloc_idx | output | IDX_W | Slot the allocated load receives |
| o_ld_alloc_sq_none | output | 1 | No store is tracked at allocation |
| o_ld_alloc_sqidx | output | SQI_W | Store tail at allocation |
| o_ld_full | output | 1 | Load queue holds LQ_DEPTH loads |
| i_ld_addr_vld | input | 1 | Address writeback strobe |
| i_ld_addr_idx | input | IDX_W | Slot receiving the address |
| i_ld_addr | input | ADDR_W | Load address |
| i_st_alloc | input | 1 | Allocate a store |
| o_st_alloc_ldidx | output | IDX_W | Load tail handed to the new store |
| o_st_full | output | 1 | Store tracker holds SQ_DEPTH stores |
| i_st_retire | input | 1 | Release the oldest tracked store |
| i_st_exec | input | 1 | Store executes; run the ordering check |
| i_st_addr | input | ADDR_W | Address of the executing store |
| i_st_ldidx | input | IDX_W | Load index recorded for that store |
| o_st_fault | output | 1 | Violation found this cycle |
| i_viol_read | input | 1 | Consume and clear the held violator |
| o_viol_vld | output | 1 | A violator is held |
| o_viol_idx | output | IDX_W | Slot of the held violator |
| o_viol_seq | output | SEQ_W | Sequence number of the held violator |
| i_commit | input | 1 | Commit up to i_commit_seq |
| i_commit_seq | input | SEQ_W | Youngest committing sequence number |
| i_squash | input | 1 | Squash loads younger than i_squash_seq |
| i_squash_seq | input | SEQ_W | Squash boundary |
| i_stall_set | input | 1 | Record a stalled load |
| i_stall_idx | input | IDX_W | Slot of the stalled load |
| i_block_set | input | 1 | Record a blocked load |
| i_block_seq | input | SEQ_W | Sequence number of the blocked load |
| o_stalled | output | 1 | Stall state present |
| o_blocked | output | 1 | Blocked-load state present |
| o_lq_count | output | CNT_W | Number of live loads |
| o_free | output | FREE_W | Free entries of the tighter queue |

## Verification
The violation search is tried with a store whose granule matches a younger load that has an address, and again while a violator is already held, to show that the held values do not move. It is also tried with a matching load that sits before the search start, which must give no fault, and with a load that has no address yet, which must give no fault until that address is written. A last run places the search range across the ring's wrap point with the queue full, which tells a true ring-order search apart from a linear index search. Commit and squash are tried with sequence boundaries that stop partway along the queue. Squash is also tried with a stalled slot inside and outside the removed range, with blocked sequence numbers on both sides of the squash number, and with allocation and commit requested in the same cycle.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

  // Modular advance of a ring index.
  function automatic int ring_add(input int a, input int b, input int size);
    return (a + b) % size;
  endfunction

  // Modular retreat of a ring index; b must not exceed size.
  function automatic int ring_sub(input int a, input int b, input int size);
    return (a - b + size) % size;
  endfunction

endpackage

// File: rtl/ldq_span_count.sv
// Counts how many consecutive ring slots, starting at base and walking
// forward or backward, satisfy cond, bounded by avail.
module ldq_span_count #(
  parameter int  SIZE     = 9,
  parameter int  IDX_W    = 4,
  parameter int  CNT_W    = 4,
  parameter bit  BACKWARD = 1'b0
) (
  input  logic [SIZE-1:0]  cond,
  input  logic [IDX_W-1:0] base,
  input  logic [CNT_W-1:0] avail,
  output logic [CNT_W-1:0] run
);
  import ldq_pkg::*;

  generate
    if (BACKWARD) begin : g_bwd
      always_comb begin
        logic open;
        run  = '0;
        open = 1'b1;
        for (int k = 0; k < SIZE; k++) begin
          int pos;
          pos = ring_sub(int'(base), k, SIZE);
          if (open && (k < int'(avail)) && cond[pos]) run = run + 1'b1;
          else open = 1'b0;
        end
      end
    end else begin : g_fwd
      always_comb begin
        logic open;
        run  = '0;
        open = 1'b1;
        for (int k = 0; k < SIZE; k++) begin
          int pos;
          pos = ring_add(int'(base), k, SIZE);
          if (open && (k < int'(avail)) && cond[pos]) run = run + 1'b1;
          else open = 1'b0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ldq_viol_scan.sv
// Single-cycle priority search over the ring range [start, stop) for the
// first live load with a known address in the store's granule.
module ldq_viol_scan #(
  parameter int SIZE       = 9,
  parameter int IDX_W      = 4,
  parameter int ADDR_W     = 32,
  parameter int GRAN_SHIFT = 8
) (
  input  logic [SIZE-1:0]             live,
  input  logic [SIZE-1:0]             addr_ok,
  input  logic [SIZE-1:0][ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]            start,
  input  logic [IDX_W-1:0]            stop,
  input  logic [ADDR_W-1:0]           st_addr,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  import ldq_pkg::*;

  logic [SIZE-1:0] same_gran;

  genvar g;
  generate
    for (g = 0; g < SIZE; g++) begin : g_cmp
      assign same_gran[g] = live[g] && addr_ok[g] &&
                            ((addr[g] >> GRAN_SHIFT) == (st_addr >> GRAN_SHIFT));
    end
  endgenerate

  always_comb begin
    int span;
    span    = ring_sub(int'(stop), int'(start), SIZE);
    hit     = 1'b0;
    hit_idx = '0;
    for (int d = 0; d < SIZE; d++) begin
      int pos;
      pos = ring_add(int'(start), d, SIZE);
      if (!hit && (d < span) && same_gran[pos]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(pos);
      end
    end
  end

endmodule

// File: rtl/ldq_hold_state.sv
// Stall and blocked-load tracking, pruned by squashes.
module ldq_hold_state #(
  parameter int SIZE  = 9,
  parameter int IDX_W = 4,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             squash,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic [SIZE-1:0]  removed,
  input  logic             stall_set,
  input  logic [IDX_W-1:0] stall_idx,
  input  logic             block_set,
  input  logic [SEQ_W-1:0] block_seq,
  output logic             stalled,
  output logic             blocked
);
  logic             stalled_q, stalled_d;
  logic [IDX_W-1:0] stall_idx_q;
  logic             stall_idx_en;
  logic             blocked_q, blocked_d;
  logic [SEQ_W-1:0] block_seq_q;
  logic             block_seq_en;

  always_comb begin
    stalled_d    = stalled_q;
    blocked_d    = blocked_q;
    stall_idx_en = 1'b0;
    block_seq_en = 1'b0;
    if (squash) begin
      if (stalled_q && removed[stall_idx_q]) stalled_d = 1'b0;
      if (blocked_q && (squash_seq < block_seq_q)) blocked_d = 1'b0;
    end else begin
      if (stall_set) begin
        stalled_d    = 1'b1;
        stall_idx_en = 1'b1;
      end
      if (block_set) begin
        blocked_d    = 1'b1;
        block_seq_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stalled_q   <= 1'b0;
      blocked_q   <= 1'b0;
      stall_idx_q <= '0;
      block_seq_q <= '0;
    end else begin
      stalled_q <= stalled_d;
      blocked_q <= blocked_d;
      if (stall_idx_en) stall_idx_q <= stall_idx;
      if (block_seq_en) block_seq_q <= block_seq;
    end
  end

  assign stalled = stalled_q;
  assign blocked = blocked_q;

endmodule

// File: rtl/ldq_order_guard.sv
module ldq_order_guard #(
  parameter  int LQ_DEPTH   = 8,
  parameter  int SQ_DEPTH   = 4,
  parameter  int SEQ_W      = 16,
  parameter  int ADDR_W     = 32,
  parameter  int GRAN_SHIFT = 8,
  localparam int LQ_SIZE    = LQ_DEPTH + 1,
  localparam int SQ_SIZE    = SQ_DEPTH + 1,
  localparam int IDX_W      = $clog2(LQ_SIZE),
  localparam int CNT_W      = $clog2(LQ_SIZE + 1),
  localparam int SQI_W      = $clog2(SQ_SIZE),
  localparam int SQC_W      = $clog2(SQ_SIZE + 1),
  localparam int MAX_SIZE   = (LQ_SIZE > SQ_SIZE) ? LQ_SIZE : SQ_SIZE,
  localparam int FREE_W     = $clog2(MAX_SIZE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_ld_alloc,
  input  logic [SEQ_W-1:0]  i_ld_seq,
  output logic [IDX_W-1:0]  o_ld_alloc_idx,
  output logic              o_ld_alloc_sq_none,
  output logic [SQI_W-1:0]  o_ld_alloc_sqidx,
  output logic              o_ld_full,
  input  logic              i_ld_addr_vld,
  input  logic [IDX_W-1:0]  i_ld_addr_idx,
  input  logic [ADDR_W-1:0] i_ld_addr,
  input  logic              i_st_alloc,
  output logic [IDX_W-1:0]  o_st_alloc_ldidx,
  output logic              o_st_full,
  input  logic              i_st_retire,
  input  logic              i_st_exec,
  input  logic [ADDR_W-1:0] i_st_addr,
  input  logic [IDX_W-1:0]  i_st_ldidx,
  output logic              o_st_fault,
  input  logic              i_viol_read,
  output logic              o_viol_vld,
  output logic [IDX_W-1:0]  o_viol_idx,
  output logic [SEQ_W-1:0]  o_viol_seq,
  input  logic              i_commit,
  input  logic [SEQ_W-1:0]  i_commit_seq,
  input  logic              i_squash,
  input  logic [SEQ_W-1:0]  i_squash_seq,
  input  logic              i_stall_set,
  input  logic [IDX_W-1:0]  i_stall_idx,
  input  logic              i_block_set,
  input  logic [SEQ_W-1:0]  i_block_seq,
  output logic              o_stalled,
  output logic              o_blocked,
  output logic [CNT_W-1:0]  o_lq_count,
  output logic [FREE_W-1:0] o_free
);
  import ldq_pkg::*;

  // Ring pointers and occupancy
  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d, tail_last;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SQI_W-1:0] sq_tail_q, sq_tail_d;
  logic [SQC_W-1:0] sq_cnt_q, sq_cnt_d;

  // Slot state
  logic [LQ_SIZE-1:0]             live_q, live_d;
  logic [LQ_SIZE-1:0]             aok_q, aok_d;
  logic [LQ_SIZE-1:0][SEQ_W-1:0]  seq_q;
  logic [LQ_SIZE-1:0][ADDR_W-1:0] addr_q;
  logic [LQ_SIZE-1:0]             seq_we, addr_we;
  logic [LQ_SIZE-1:0]             old_enough, too_young;
  logic [LQ_SIZE-1:0]             commit_kill, squash_kill;

  // Violator latch
  logic             viol_q, viol_d;
  logic [IDX_W-1:0] viol_idx_q;
  logic [SEQ_W-1:0] viol_seq_q;
  logic             viol_cap;

  logic             ld_full, st_full;
  logic             alloc_go, commit_go, st_alloc_go, st_ret_go;
  logic [CNT_W-1:0] commit_run, squash_run;
  logic             scan_hit;
  logic [IDX_W-1:0] scan_idx;

  // ---------------------------------------------------------------- control
  assign ld_full     = (cnt_q == CNT_W'(LQ_DEPTH));
  assign st_full     = (sq_cnt_q == SQC_W'(SQ_DEPTH));
  assign alloc_go    = i_ld_alloc && !ld_full && !i_squash;
  assign commit_go   = i_commit && !i_squash;
  assign st_alloc_go = i_st_alloc && !st_full;
  assign st_ret_go   = i_st_retire && (sq_cnt_q != '0);
  assign tail_last   = IDX_W'(ring_sub(int'(tail_q), 1, LQ_SIZE));

  // ------------------------------------------------- per-slot age compares
  genvar s;
  generate
    for (s = 0; s < LQ_SIZE; s++) begin : g_age
      assign old_enough[s] = (seq_q[s] <= i_commit_seq);
      assign too_young[s]  = (seq_q[s] >  i_squash_seq);
    end
  endgenerate

  ldq_span_count #(
    .SIZE(LQ_SIZE), .IDX_W(IDX_W), .CNT_W(CNT_W), .BACKWARD(1'b0)
  ) u_commit_span (
    .cond(old_enough), .base(head_q), .avail(cnt_q), .run(commit_run)
  );

  ldq_span_count #(
    .SIZE(LQ_SIZE), .IDX_W(IDX_W), .CNT_W(CNT_W), .BACKWARD(1'b1)
  ) u_squash_span (
    .cond(too_young), .base(tail_last), .avail(cnt_q), .run(squash_run)
  );

  // ------------------------------------------------------- slot next state
  generate
    for (s = 0; s < LQ_SIZE; s++) begin : g_slot
      assign commit_kill[s] = commit_go &&
               (ring_sub(s, int'(head_q), LQ_SIZE) < int'(commit_run));
      assign squash_kill[s] = i_squash &&
               (ring_sub(int'(tail_last), s, LQ_SIZE) < int'(squash_run));
      assign seq_we[s]  = alloc_go && (tail_q == IDX_W'(s));
      assign addr_we[s] = i_ld_addr_vld && (i_ld_addr_idx == IDX_W'(s)) && live_q[s];
      assign live_d[s]  = seq_we[s] ||
                          (live_q[s] && !commit_kill[s] && !squash_kill[s]);
      assign aok_d[s]   = !seq_we[s] && (addr_we[s] || aok_q[s]) &&
                          !commit_kill[s] && !squash_kill[s];

      always_ff @(posedge clk) begin
        if (seq_we[s])  seq_q[s]  <= i_ld_seq;
        if (addr_we[s]) addr_q[s] <= i_ld_addr;
      end
    end
  endgenerate

  // ----------------------------------------------------- pointer next state
  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (i_squash) begin
      tail_d = IDX_W'(ring_sub(int'(tail_q), int'(squash_run), LQ_SIZE));
      cnt_d  = cnt_q - squash_run;
    end else begin
      if (commit_go) head_d = IDX_W'(ring_add(int'(head_q), int'(commit_run), LQ_SIZE));
      if (alloc_go)  tail_d = IDX_W'(ring_add(int'(tail_q), 1, LQ_SIZE));
      cnt_d = cnt_q + CNT_W'(alloc_go) - (commit_go ? commit_run : '0);
    end
  end

  always_comb begin
    sq_tail_d = st_alloc_go ? SQI_W'(ring_add(int'(sq_tail_q), 1, SQ_SIZE)) : sq_tail_q;
    sq_cnt_d  = sq_cnt_q + SQC_W'(st_alloc_go) - SQC_W'(st_ret_go);
  end

  // -------------------------------------------------------- violation check
  ldq_viol_scan #(
    .SIZE(LQ_SIZE), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .GRAN_SHIFT(GRAN_SHIFT)
  ) u_scan (
    .live(live_q), .addr_ok(aok_q), .addr(addr_q),
    .start(i_st_ldidx), .stop(tail_q), .st_addr(i_st_addr),
    .hit(scan_hit), .hit_idx(scan_idx)
  );

  assign viol_cap = i_st_exec && !viol_q && scan_hit;

  always_comb begin
    viol_d = viol_q;
    if (viol_cap)         viol_d = 1'b1;
    else if (i_viol_read) viol_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (viol_cap) begin
      viol_idx_q <= scan_idx;
      viol_seq_q <= seq_q[scan_idx];
    end
  end

  // ---------------------------------------------------- stall / block state
  ldq_hold_state #(
    .SIZE(LQ_SIZE), .IDX_W(IDX_W), .SEQ_W(SEQ_W)
  ) u_hold (
    .clk(clk), .rst_n(rst_n),
    .squash(i_squash), .squash_seq(i_squash_seq), .removed(squash_kill),
    .stall_set(i_stall_set), .stall_idx(i_stall_idx),
    .block_set(i_block_set), .block_seq(i_block_seq),
    .stalled(o_stalled), .blocked(o_blocked)
  );

  // -------------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q    <= '0;
      tail_q    <= '0;
      cnt_q     <= '0;
      sq_tail_q <= '0;
      sq_cnt_q  <= '0;
      live_q    <= '0;
      aok_q     <= '0;
      viol_q    <= 1'b0;
    end else begin
      head_q    <= head_d;
      tail_q    <= tail_d;
      cnt_q     <= cnt_d;
      sq_tail_q <= sq_tail_d;
      sq_cnt_q  <= sq_cnt_d;
      live_q    <= live_d;
      aok_q     <= aok_d;
      viol_q    <= viol_d;
    end
  end

  // ---------------------------------------------------------------- outputs
  always_comb begin
    int lq_room, sq_room;
    lq_room = LQ_SIZE - int'(cnt_q);
    sq_room = SQ_SIZE - int'(sq_cnt_q);
    o_free  = FREE_W'(((lq_room < sq_room) ? lq_room : sq_room) - 1);
  end

  assign o_ld_alloc_idx     = tail_q;
  assign o_ld_alloc_sq_none = (sq_cnt_q == '0);
  assign o_ld_alloc_sqidx   = sq_tail_q;
  assign o_ld_full          = ld_full;
  assign o_st_alloc_ldidx   = tail_q;
  assign o_st_full          = st_full;
  assign o_st_fault         = viol_cap;
  assign o_viol_vld         = viol_q;
  assign o_viol_idx         = viol_idx_q;
  assign o_viol_seq         = viol_seq_q;
  assign o_lq_count         = cnt_q;

endmodule

// File: rtl/ldq_order_guard_chk.sv
module ldq_order_guard_chk #(
  parameter  int LQ_DEPTH = 8,
  parameter  int SEQ_W    = 16,
  localparam int LQ_SIZE  = LQ_DEPTH + 1,
  localparam int IDX_W    = $clog2(LQ_SIZE),
  localparam int CNT_W    = $clog2(LQ_SIZE + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             i_ld_alloc,
  input logic             o_ld_full,
  input logic             i_st_exec,
  input logic             o_st_fault,
  input logic             i_viol_read,
  input logic             o_viol_vld,
  input logic [IDX_W-1:0] o_viol_idx,
  input logic [SEQ_W-1:0] o_viol_seq,
  input logic             i_commit,
  input logic             i_squash,
  input logic             o_blocked,
  input logic [CNT_W-1:0] o_lq_count
);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    o_lq_count <= CNT_W'(LQ_DEPTH));

  a_r2_full_drops_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    o_ld_full && i_ld_alloc && !i_squash && !i_commit |=> $stable(o_lq_count));

  a_r5_fault_gated: assert property (@(posedge clk) disable iff (!rst_n)
    o_st_fault |-> i_st_exec && !o_viol_vld);

  a_r5_fault_latches: assert property (@(posedge clk) disable iff (!rst_n)
    o_st_fault |=> o_viol_vld);

  a_r7_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    o_viol_vld && !i_viol_read |=> o_viol_vld && $stable(o_viol_idx) && $stable(o_viol_seq));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    o_viol_vld && i_viol_read |=> !o_viol_vld);

  a_r8_commit_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    i_commit && !i_ld_alloc |=> o_lq_count <= $past(o_lq_count));

  a_r12_squash_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    i_squash |=> o_lq_count <= $past(o_lq_count));

  a_r11_block_needs_squash: assert property (@(posedge clk) disable iff (!rst_n)
    o_blocked && !i_squash |=> o_blocked);

endmodule

bind ldq_order_guard ldq_order_guard_chk #(
  .LQ_DEPTH(LQ_DEPTH), .SEQ_W(SEQ_W)
) chk_i (.*);

// File: tb/ldq_order_guard_tb_top.sv
`timescale 1ns/1ps
module ldq_order_guard_tb_top;
  localparam int LQ_DEPTH = 8;
  localparam int SQ_DEPTH = 4;
  localparam int SEQ_W    = 16;
  localparam int ADDR_W   = 32;
  localparam int IDX_W    = 4;
  localparam int SQI_W    = 3;
  localparam int CNT_W    = 4;
  localparam int FREE_W   = 4;

  logic clk, rst_n;
  logic i_ld_alloc; logic [SEQ_W-1:0] i_ld_seq;
  logic [IDX_W-1:0] o_ld_alloc_idx; logic o_ld_alloc_sq_none;
  logic [SQI_W-1:0] o_ld_alloc_sqidx; logic o_ld_full;
  logic i_ld_addr_vld; logic [IDX_W-1:0] i_ld_addr_idx; logic [ADDR_W-1:0] i_ld_addr;
  logic i_st_alloc; logic [IDX_W-1:0] o_st_alloc_ldidx; logic o_st_full; logic i_st_retire;
  logic i_st_exec; logic [ADDR_W-1:0] i_st_addr; logic [IDX_W-1:0] i_st_ldidx; logic o_st_fault;
  logic i_viol_read; logic o_viol_vld; logic [IDX_W-1:0] o_viol_idx; logic [SEQ_W-1:0] o_viol_seq;
  logic i_commit; logic [SEQ_W-1:0] i_commit_seq;
  logic i_squash; logic [SEQ_W-1:0] i_squash_seq;
  logic i_stall_set; logic [IDX_W-1:0] i_stall_idx;
  logic i_block_set; logic [SEQ_W-1:0] i_block_seq;
  logic o_stalled, o_blocked;
  logic [CNT_W-1:0] o_lq_count; logic [FREE_W-1:0] o_free;

  int n_chk, n_fail;

  ldq_order_guard #(.LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH), .SEQ_W(SEQ_W),
                    .ADDR_W(ADDR_W), .GRAN_SHIFT(8)) dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle();
    i_ld_alloc = 0; i_ld_seq = '0; i_ld_addr_vld = 0; i_ld_addr_idx = '0; i_ld_addr = '0;
    i_st_alloc = 0; i_st_retire = 0; i_st_exec = 0; i_st_addr = '0; i_st_ldidx = '0;
    i_viol_read = 0; i_commit = 0; i_commit_seq = '0; i_squash = 0; i_squash_seq = '0;
    i_stall_set = 0; i_stall_idx = '0; i_block_set = 0; i_block_seq = '0;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk); idle(); #1;
  endtask

  task automatic do_reset();
    idle(); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1; #1;
  endtask

  task automatic ld_alloc(input int seq);
    i_ld_alloc = 1; i_ld_seq = SEQ_W'(seq); cyc();
  endtask

  task automatic ld_addr(input int idx, input int a);
    i_ld_addr_vld = 1; i_ld_addr_idx = IDX_W'(idx); i_ld_addr = ADDR_W'(a); cyc();
  endtask

  task automatic st_exec(input int ldidx, input int a, input bit exp_fault, input string req);
    i_st_exec = 1; i_st_ldidx = IDX_W'(ldidx); i_st_addr = ADDR_W'(a); #1;
    chk(req, o_st_fault, exp_fault);
    cyc();
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 count", o_lq_count, 0);
    chk("R1 free", o_free, 4);
    chk("R1 viol", o_viol_vld, 0);
    chk("R1 full", o_ld_full, 0);
    chk("R1 stalled", o_stalled, 0);
    chk("R1 blocked", o_blocked, 0);
  endtask

  task automatic t_alloc_tags();
    do_reset();
    for (int k = 0; k < 3; k++) begin
      i_ld_alloc = 1; i_ld_seq = SEQ_W'(10 * (k + 1)); #1;
      chk("R2 alloc idx", o_ld_alloc_idx, k);
      chk("R2 no store tag", o_ld_alloc_sq_none, 1);
      cyc();
    end
    i_st_alloc = 1; #1;
    chk("R3 store gets load tail", o_st_alloc_ldidx, 3);
    cyc();
    i_ld_alloc = 1; i_ld_seq = 40; #1;
    chk("R2 alloc idx", o_ld_alloc_idx, 3);
    chk("R2 store tag valid", o_ld_alloc_sq_none, 0);
    chk("R2 store tail tag", o_ld_alloc_sqidx, 1);
    cyc();
    chk("R4 free 4 loads 1 store", o_free, 3);
    for (int k = 0; k < 3; k++) begin i_st_alloc = 1; cyc(); end
    chk("R3 store full", o_st_full, 1);
    chk("R4 free at store full", o_free, 0);
    i_st_alloc = 1; cyc();
    chk("R3 extra store dropped", o_free, 0);
    i_st_retire = 1; cyc();
    chk("R4 free after retire", o_free, 1);
    i_ld_alloc = 1; i_ld_seq = 50; #1;
    chk("R2 store tail tag after drop", o_ld_alloc_sqidx, 4);
    cyc();
  endtask

  task automatic t_violation();
    do_reset();
    ld_alloc(10); ld_alloc(20); ld_alloc(30); ld_alloc(40);
    ld_addr(0, 'h1234); ld_addr(2, 'h5678); ld_addr(3, 'h56AB);
    st_exec(1, 'h5600, 1, "R5 fault pulse");
    chk("R5 viol vld", o_viol_vld, 1);
    chk("R5 viol idx oldest", o_viol_idx, 2);
    chk("R5 viol seq", o_viol_seq, 30);
    st_exec(3, 'h56FF, 0, "R7 no check while held");
    chk("R7 idx held", o_viol_idx, 2);
    chk("R7 seq held", o_viol_seq, 30);
    i_viol_read = 1; cyc();
    chk("R7 read clears", o_viol_vld, 0);
    st_exec(3, 'h5600, 1, "R5 second fault");
    chk("R5 viol idx 3", o_viol_idx, 3);
    chk("R5 viol seq 40", o_viol_seq, 40);
    i_viol_read = 1; cyc();
    st_exec(1, 'h1200, 0, "R5 older load outside range");
    st_exec(1, 'h0000, 0, "R6 unknown address");
    ld_addr(1, 'h0010);
    st_exec(1, 'h0000, 1, "R6 address now known");
    chk("R6 viol idx 1", o_viol_idx, 1);
    chk("R6 viol seq 20", o_viol_seq, 20);
    i_viol_read = 1; cyc();
  endtask

  task automatic t_commit();
    do_reset();
    ld_alloc(10); ld_alloc(20); ld_alloc(30); ld_alloc(40);
    i_commit = 1; i_commit_seq = 25; cyc();
    chk("R8 partial commit", o_lq_count, 2);
    i_commit = 1; i_commit_seq = 5; cyc();
    chk("R8 nothing old enough", o_lq_count, 2);
    i_commit = 1; i_commit_seq = 30; cyc();
    chk("R8 one more", o_lq_count, 1);
    i_ld_alloc = 1; i_ld_seq = 50; #1;
    chk("R8 tail unaffected", o_ld_alloc_idx, 4);
    cyc();
  endtask

  task automatic t_squash();
    do_reset();
    ld_alloc(30); ld_alloc(40); ld_alloc(50); ld_alloc(60);
    i_stall_set = 1; i_stall_idx = 3; i_block_set = 1; i_block_seq = 55; cyc();
    chk("R10 stalled set", o_stalled, 1);
    chk("R11 blocked set", o_blocked, 1);
    i_squash = 1; i_squash_seq = 45; cyc();
    chk("R9 squash count", o_lq_count, 2);
    chk("R10 stall cleared", o_stalled, 0);
    chk("R11 block cleared", o_blocked, 0);
    i_ld_alloc = 1; i_ld_seq = 70; #1;
    chk("R9 tail pulled back", o_ld_alloc_idx, 2);
    cyc();
    i_stall_set = 1; i_stall_idx = 0; i_block_set = 1; i_block_seq = 40; cyc();
    i_squash = 1; i_squash_seq = 45; cyc();
    chk("R9 squash one", o_lq_count, 2);
    chk("R10 stall kept", o_stalled, 1);
    chk("R11 block kept", o_blocked, 1);
    i_squash = 1; i_squash_seq = 35; cyc();
    chk("R9 squash stops at older", o_lq_count, 1);
    chk("R11 block cleared below", o_blocked, 0);
    chk("R10 stall kept", o_stalled, 1);
  endtask

  task automatic t_squash_prio();
    do_reset();
    ld_alloc(10); ld_alloc(20);
    i_squash = 1; i_squash_seq = 15; i_ld_alloc = 1; i_ld_seq = 99;
    i_commit = 1; i_commit_seq = 20; cyc();
    chk("R12 squash only", o_lq_count, 1);
    i_ld_alloc = 1; i_ld_seq = 30; #1;
    chk("R12 alloc ignored", o_ld_alloc_idx, 1);
    cyc();
  endtask

  task automatic t_wrap_full();
    do_reset();
    for (int k = 1; k <= 6; k++) ld_alloc(k);
    i_commit = 1; i_commit_seq = 6; cyc();
    chk("R8 drain", o_lq_count, 0);
    for (int k = 0; k < 8; k++) begin
      i_ld_alloc = 1; i_ld_seq = SEQ_W'(11 + k); #1;
      chk("R2 wrapped idx", o_ld_alloc_idx, (6 + k) % 9);
      cyc();
    end
    chk("R2 full", o_ld_full, 1);
    chk("R4 free when full", o_free, 0);
    ld_alloc(19);
    chk("R2 full drops alloc", o_lq_count, 8);
    ld_addr(8, 'h0900); ld_addr(1, 'h09FF);
    st_exec(7, 'h0955, 1, "R5 wrapped scan");
    chk("R5 wrapped idx", o_viol_idx, 8);
    chk("R5 wrapped seq", o_viol_seq, 13);
    i_viol_read = 1; cyc();
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    idle(); rst_n = 1'b0;
    t_reset_state();
    t_alloc_tags();
    t_violation();
    t_commit();
    t_squash();
    t_squash_prio();
    t_wrap_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule